// File: doc/BRIEF.md
# Keypad Matrix Scanner

This block scans a matrix of keys of up to 8 rows by 8 columns. Columns are driven open-drain: a column is pulled low by enabling its output driver with a zero data value. Rows are inputs with pull-ups, so a pressed key pulls its row low while its column is driven. Every row input is synchronised and passes a glitch filter. Every key is then debounced over whole scans, so any number of keys held together is reported in a 64-bit state map. Per-key sticky flags record presses and releases until software clears them by writing ones.

A key held past a programmable number of scans raises a long-press indication. In standby mode the scanner stops, all matrix columns are driven low together, and any low row raises a wake output. Once wake is raised the block goes back to scanning column by column. Any row or column that is not part of the matrix is handed to general-purpose I/O control.

Top module: `keymx_scan`

## Requirements
- R1: While scanning, each matrix column in turn from 0 upward is driven (col_oe_o=1, col_do_o=0) for DWELL_CYC cycles with all other matrix columns released, starting at column 0 in the first cycle that scanning is active. A disabled column keeps its time slot but is not driven.
- R2: A row input level that lasts glitch_min_i cycles or fewer is filtered out and has no effect. A level must hold glitch_min_i+1 cycles to be seen.
- R3: A key's reported state in key_map_o changes only after its sampled level has differed from the reported state on db_scans_i consecutive scans (a value of 0 acts as 1).
- R4: Several keys held together are all reported. Key at row r, column c is bit r*COLS+c of every 64-bit key vector.
- R5: press_flag_o bit k sets in the cycle key_map_o bit k rises and stays set until a cycle with press_clr_i bit k high. A new press in that same cycle wins.
- R6: rel_flag_o bit k sets in the cycle key_map_o bit k falls and is cleared by rel_clr_i bit k in the same way.
- R7: long_o bit k is high while key k is reported pressed and has been sampled pressed on at least long_scans_i scans since its press was reported. It drops on release, and long_scans_i=0 disables it.
- R8: With standby_i high and no pending wake, all enabled columns are driven low at once and no key is sampled. A filtered low on any enabled row sets wake_o, which returns the block to per-column scanning until wake_clr_i clears wake_o.
- R9: A column with col_en_i low takes col_oe_o/col_do_o from gpio_col_oe_i/gpio_col_do_i. A row with row_en_i low takes row_oe_o/row_do_o from the GPIO inputs. Enabled rows are never driven. Keys in a disabled row or column read as released.
- R10: After reset key_map_o, both flag vectors, long_o and wake_o are zero, and no column is driven by the matrix logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_en_i | input | 1 | Run per-column scanning |
| standby_i | input | 1 | Standby: drive all enabled columns, watch rows |
| wake_clr_i | input | 1 | Clear wake_o |
| col_en_i | input | COLS | Column belongs to the matrix (else GPIO) |
| row_en_i | input | ROWS | Row belongs to the matrix (else GPIO) |
| db_scans_i | input | DB_W | Consecutive scans needed to change a key state |
| glitch_min_i | input | GL_W | Longest row pulse, in cycles, that is rejected |
| long_scans_i | input | LP_W | Scans held before long-press indication |
| row_i | input | ROWS | Row pad levels |
| gpio_row_do_i | input | ROWS | GPIO data for non-matrix rows |
| gpio_row_oe_i | input | ROWS | GPIO enable for non-matrix rows |
| gpio_col_do_i | input | COLS | GPIO data for non-matrix columns |
| gpio_col_oe_i | input | COLS | GPIO enable for non-matrix columns |
| press_clr_i | input | ROWS*COLS | Write-one-to-clear for press flags |
| rel_clr_i | input | ROWS*COLS | Write-one-to-clear for release flags |
| col_do_o | output | COLS | Column pad data |
| col_oe_o | output | COLS | Column pad driver enable |
| row_do_o | output | ROWS | Row pad data |
| row_oe_o | output | ROWS | Row pad driver enable |
| gpio_row_o | output | ROWS | Synchronised row levels for GPIO reads |
| key_map_o | output | ROWS*COLS | Debounced key state, 1 = pressed |
| press_flag_o | output | ROWS*COLS | Sticky press events |
| rel_flag_o | output | ROWS*COLS | Sticky release events |
| long_o | output | ROWS*COLS | Long-press indication |
| wake_o | output | 1 | Key activity seen in standby |

## Verification
A column sequencer that slips shows at once on col_oe_o, since the driven column no longer matches its time slot. It also later shows a key reported in the wrong bit of key_map_o. A debounce or hold counter in the wrong state shows only after several full scans, as a key_map_o or long_o edge that comes too early, too late or never. A glitch filter or wake flag in the wrong state shows within a few tens of cycles in standby, as wake_o rising on a short pulse or staying low on a held key. Flag faults show in the cycle after a map edge or a clear.

// File: rtl/keymx_pkg.sv
package keymx_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_SCAN = 2'd1,
    MODE_STBY = 2'd2
  } keymx_mode_e;

  function automatic int key_bit(int r, int c, int cols);
    return r * cols + c;
  endfunction
endpackage

// File: rtl/keymx_col_seq.sv
module keymx_col_seq
  import keymx_pkg::*;
#(
  parameter int COLS      = 8,
  parameter int DWELL_CYC = 16,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int DW = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  keymx_mode_e     mode_i,
  input  logic [COLS-1:0] col_en_i,
  output logic [COLS-1:0] drv_o,
  output logic [CW-1:0]   col_idx_o,
  output logic            sample_o
);
  logic [DW-1:0] dwell_q;
  logic [CW-1:0] idx_q;
  logic          last_dwell;

  assign last_dwell = (dwell_q == DW'(DWELL_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dwell_q <= '0;
      idx_q   <= '0;
    end else if (mode_i != MODE_SCAN) begin
      dwell_q <= '0;
      idx_q   <= '0;
    end else if (last_dwell) begin
      dwell_q <= '0;
      idx_q   <= (idx_q == CW'(COLS - 1)) ? '0 : idx_q + 1'b1;
    end else begin
      dwell_q <= dwell_q + 1'b1;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_drv
    always_comb begin
      unique case (mode_i)
        MODE_SCAN: drv_o[c] = col_en_i[c] & (idx_q == CW'(c));
        MODE_STBY: drv_o[c] = col_en_i[c];
        default:   drv_o[c] = 1'b0;
      endcase
    end
  end

  assign col_idx_o = idx_q;
  assign sample_o  = (mode_i == MODE_SCAN) && last_dwell;
endmodule

// File: rtl/keymx_row_filt.sv
module keymx_row_filt #(
  parameter int ROWS = 8,
  parameter int GL_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ROWS-1:0] row_i,
  input  logic [GL_W-1:0] glitch_min_i,
  output logic [ROWS-1:0] sync_o,
  output logic [ROWS-1:0] filt_o
);
  logic [ROWS-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= row_i;
      s2_q <= s1_q;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [GL_W-1:0] cnt_q;
    logic            lvl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        lvl_q <= 1'b1;
      end else if (s2_q[r] == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q >= glitch_min_i) begin
        // level held long enough: accept it
        lvl_q <= s2_q[r];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
    assign filt_o[r] = lvl_q;
  end

  assign sync_o = s2_q;
endmodule

// File: rtl/keymx_key_cell.sv
module keymx_key_cell #(
  parameter int DB_W = 4,
  parameter int LP_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sample_i,
  input  logic            raw_press_i,
  input  logic [DB_W-1:0] db_scans_i,
  input  logic [LP_W-1:0] long_scans_i,
  input  logic            press_clr_i,
  input  logic            rel_clr_i,
  output logic            state_o,
  output logic            press_o,
  output logic            rel_o,
  output logic            long_o
);
  logic [DB_W-1:0] need, cnt_q;
  logic [LP_W-1:0] held_q;
  logic            state_q, press_q, rel_q;
  logic            flip, ev_press, ev_rel;

  assign need     = (db_scans_i == '0) ? DB_W'(1) : db_scans_i;
  assign flip     = sample_i && (raw_press_i != state_q) && ((cnt_q + 1'b1) >= need);
  assign ev_press = flip && raw_press_i;
  assign ev_rel   = flip && !raw_press_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      state_q <= 1'b0;
    end else if (sample_i) begin
      if (flip) begin
        state_q <= raw_press_i;
        cnt_q   <= '0;
      end else if (raw_press_i != state_q) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
    end else if (ev_press) begin
      held_q <= '0;
    end else if (sample_i && state_q && raw_press_i && (held_q != '1)) begin
      held_q <= held_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      press_q <= 1'b0;
      rel_q   <= 1'b0;
    end else begin
      press_q <= (press_q & ~press_clr_i) | ev_press;
      rel_q   <= (rel_q & ~rel_clr_i) | ev_rel;
    end
  end

  assign state_o = state_q;
  assign press_o = press_q;
  assign rel_o   = rel_q;
  assign long_o  = state_q && (long_scans_i != '0) && (held_q >= long_scans_i);
endmodule

// File: rtl/keymx_scan.sv
module keymx_scan
  import keymx_pkg::*;
#(
  parameter int ROWS      = 8,
  parameter int COLS      = 8,
  parameter int DWELL_CYC = 16,
  parameter int DB_W      = 4,
  parameter int GL_W      = 4,
  parameter int LP_W      = 8,
  localparam int NK = ROWS * COLS,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scan_en_i,
  input  logic            standby_i,
  input  logic            wake_clr_i,
  input  logic [COLS-1:0] col_en_i,
  input  logic [ROWS-1:0] row_en_i,
  input  logic [DB_W-1:0] db_scans_i,
  input  logic [GL_W-1:0] glitch_min_i,
  input  logic [LP_W-1:0] long_scans_i,
  input  logic [ROWS-1:0] row_i,
  input  logic [ROWS-1:0] gpio_row_do_i,
  input  logic [ROWS-1:0] gpio_row_oe_i,
  input  logic [COLS-1:0] gpio_col_do_i,
  input  logic [COLS-1:0] gpio_col_oe_i,
  input  logic [NK-1:0]   press_clr_i,
  input  logic [NK-1:0]   rel_clr_i,
  output logic [COLS-1:0] col_do_o,
  output logic [COLS-1:0] col_oe_o,
  output logic [ROWS-1:0] row_do_o,
  output logic [ROWS-1:0] row_oe_o,
  output logic [ROWS-1:0] gpio_row_o,
  output logic [NK-1:0]   key_map_o,
  output logic [NK-1:0]   press_flag_o,
  output logic [NK-1:0]   rel_flag_o,
  output logic [NK-1:0]   long_o,
  output logic            wake_o
);
  keymx_mode_e     mode;
  logic            wake_q, stby_act, scan_act, smp_stb, any_low;
  logic [COLS-1:0] mat_drv;
  logic [CW-1:0]   col_idx;
  logic [ROWS-1:0] row_f;

  assign stby_act = standby_i & ~wake_q;
  assign scan_act = ~stby_act & (scan_en_i | wake_q);

  always_comb begin
    if (stby_act)      mode = MODE_STBY;
    else if (scan_act) mode = MODE_SCAN;
    else               mode = MODE_OFF;
  end

  assign any_low = |(~row_f & row_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  wake_q <= 1'b0;
    else if (stby_act && any_low) wake_q <= 1'b1;
    else if (wake_clr_i)          wake_q <= 1'b0;
  end
  assign wake_o = wake_q;

  keymx_col_seq #(.COLS(COLS), .DWELL_CYC(DWELL_CYC)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .col_en_i  (col_en_i),
    .drv_o     (mat_drv),
    .col_idx_o (col_idx),
    .sample_o  (smp_stb)
  );

  keymx_row_filt #(.ROWS(ROWS), .GL_W(GL_W)) u_filt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .row_i        (row_i),
    .glitch_min_i (glitch_min_i),
    .sync_o       (gpio_row_o),
    .filt_o       (row_f)
  );

  // open drain: a matrix column only ever drives zero
  for (genvar c = 0; c < COLS; c++) begin : g_col_pad
    assign col_oe_o[c] = col_en_i[c] ? mat_drv[c] : gpio_col_oe_i[c];
    assign col_do_o[c] = col_en_i[c] ? 1'b0       : gpio_col_do_i[c];
  end
  assign row_oe_o = ~row_en_i & gpio_row_oe_i;
  assign row_do_o = ~row_en_i & gpio_row_do_i;

  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      localparam int K = key_bit(r, c, COLS);
      keymx_key_cell #(.DB_W(DB_W), .LP_W(LP_W)) u_key (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sample_i     (smp_stb && (col_idx == CW'(c))),
        .raw_press_i  (row_en_i[r] & col_en_i[c] & ~row_f[r]),
        .db_scans_i   (db_scans_i),
        .long_scans_i (long_scans_i),
        .press_clr_i  (press_clr_i[K]),
        .rel_clr_i    (rel_clr_i[K]),
        .state_o      (key_map_o[K]),
        .press_o      (press_flag_o[K]),
        .rel_o        (rel_flag_o[K]),
        .long_o       (long_o[K])
      );
    end
  end
endmodule

// File: rtl/keymx_scan_chk.sv
module keymx_scan_chk #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int NK = ROWS * COLS
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [COLS-1:0] col_en_i,
  input logic [COLS-1:0] col_oe_o,
  input logic [COLS-1:0] col_do_o,
  input logic [COLS-1:0] mat_drv,
  input logic            scan_act,
  input logic            stby_act,
  input logic            smp_stb,
  input logic [NK-1:0]   key_map_o,
  input logic [NK-1:0]   press_flag_o,
  input logic [NK-1:0]   rel_flag_o,
  input logic [NK-1:0]   press_clr_i,
  input logic [NK-1:0]   long_o,
  input logic            wake_o
);
  assert_one_col_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_act |-> $onehot0(col_oe_o & col_en_i));

  assert_gpio_col_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mat_drv & ~col_en_i) == '0);

  assert_stby_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_act |-> (((col_oe_o & col_en_i) == col_en_i) && ((col_do_o & col_en_i) == '0)));

  assert_map_on_sample_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(smp_stb) |-> $stable(key_map_o));

  assert_press_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_map_o & ~$past(key_map_o) & ~press_flag_o) == '0);

  assert_press_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(press_clr_i) & press_flag_o & ~(key_map_o & ~$past(key_map_o))) == '0);

  assert_rel_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~key_map_o & $past(key_map_o) & ~rel_flag_o) == '0);

  assert_long_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (long_o & ~key_map_o) == '0);

  assert_wake_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(stby_act));
endmodule

bind keymx_scan keymx_scan_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .col_en_i     (col_en_i),
  .col_oe_o     (col_oe_o),
  .col_do_o     (col_do_o),
  .mat_drv      (mat_drv),
  .scan_act     (scan_act),
  .stby_act     (stby_act),
  .smp_stb      (smp_stb),
  .key_map_o    (key_map_o),
  .press_flag_o (press_flag_o),
  .rel_flag_o   (rel_flag_o),
  .press_clr_i  (press_clr_i),
  .long_o       (long_o),
  .wake_o       (wake_o)
);

// File: tb/keymx_scan_tb_top.sv
module keymx_scan_tb_top;
  localparam int ROWS = 8, COLS = 8, DWELL = 16, NK = 64;
  localparam int SCAN = COLS * DWELL;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scan_en = 0, standby = 0, wake_clr = 0;
  logic [COLS-1:0] col_en = '1, gpio_col_do = '0, gpio_col_oe = '0;
  logic [ROWS-1:0] row_en = '1, gpio_row_do = '0, gpio_row_oe = '0, row_in, gl_mask = '0;
  logic [3:0] db = 4'd3, glmin = 4'd2;
  logic [7:0] lp = 8'd5;
  logic [NK-1:0] press_clr = '0, rel_clr = '0, keys = '0;
  logic [COLS-1:0] col_do, col_oe;
  logic [ROWS-1:0] row_do, row_oe, gpio_row;
  logic [NK-1:0] kmap, pflag, rflag, lng;
  logic wake;

  keymx_scan dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scan_en_i(scan_en), .standby_i(standby),
    .wake_clr_i(wake_clr), .col_en_i(col_en), .row_en_i(row_en),
    .db_scans_i(db), .glitch_min_i(glmin), .long_scans_i(lp), .row_i(row_in),
    .gpio_row_do_i(gpio_row_do), .gpio_row_oe_i(gpio_row_oe),
    .gpio_col_do_i(gpio_col_do), .gpio_col_oe_i(gpio_col_oe),
    .press_clr_i(press_clr), .rel_clr_i(rel_clr),
    .col_do_o(col_do), .col_oe_o(col_oe), .row_do_o(row_do), .row_oe_o(row_oe),
    .gpio_row_o(gpio_row), .key_map_o(kmap), .press_flag_o(pflag),
    .rel_flag_o(rflag), .long_o(lng), .wake_o(wake)
  );

  // key matrix model: pulled-up rows, pressed key shorts row to its column
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      logic low;
      low = 1'b0;
      for (int c = 0; c < COLS; c++)
        if (keys[r*COLS+c] && col_oe[c] && !col_do[c]) low = 1'b1;
      row_in[r] = ~low & ~gl_mask[r];
    end
  end

  typedef struct {
    int          sel;
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  int n_chk = 0, n_err = 0;

  function automatic logic [63:0] observe(int sel);
    case (sel)
      0: return 64'(col_oe);
      1: return 64'(col_do);
      2: return kmap;
      3: return pflag;
      4: return rflag;
      5: return lng;
      6: return 64'(wake);
      7: return 64'(row_oe);
      default: return 64'(gpio_row);
    endcase
  endfunction

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it = sb_q.pop_front();
      act = observe(it.sel);
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_v(int sel, logic [63:0] v, string tag);
    item_t it;
    it.sel = sel; it.exp = v; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic settle();
    tick(1);
  endtask

  function automatic logic [63:0] kb(int r, int c);
    return 64'(1) << (r*COLS + c);
  endfunction

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] k8, k28, k55, k25;
    k8 = kb(1,0); k28 = kb(3,4); k55 = kb(6,7); k25 = kb(3,1);
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R10 reset state
    expect_v(2, 0, "R10 map"); expect_v(3, 0, "R10 press");
    expect_v(6, 0, "R10 wake"); expect_v(0, 0, "R10 col_oe");
    settle();

    // R1 column order, column 2 disabled
    col_en = 8'hFB;
    scan_en = 1'b1;
    expect_v(0, 64'h01, "R1 col0 start");
    tick(DWELL - 1);
    expect_v(0, 64'h01, "R1 col0 end");
    tick(1);
    expect_v(0, 64'h02, "R1 col1");
    expect_v(1, 64'h00, "R1 open drain");
    tick(DWELL);
    expect_v(0, 64'h00, "R1 disabled col2");
    tick(DWELL);
    expect_v(0, 64'h08, "R1 col3");
    settle();

    // R3/R4 multiple keys, debounce
    keys = k8 | k28 | k55;
    tick(SCAN);
    expect_v(2, 0, "R3 not yet debounced");
    tick(4*SCAN);
    expect_v(2, k8|k28|k55, "R4 multi key map");
    expect_v(3, k8|k28|k55, "R5 press flags");
    expect_v(5, 0, "R7 not long yet");
    settle();

    // R5 clear by write one
    press_clr = k8;
    tick(1);
    press_clr = '0;
    expect_v(3, k28|k55, "R5 clear");
    settle();

    // R7 long press
    tick(8*SCAN);
    expect_v(5, k8|k28|k55, "R7 long held");
    settle();

    // R6 release
    keys = k8 | k55;
    tick(5*SCAN);
    expect_v(2, k8|k55, "R6 map after release");
    expect_v(4, k28, "R6 release flag");
    expect_v(5, k8|k55, "R7 long drops on release");
    settle();

    // R9 GPIO reassignment
    row_en = 8'hBF; gpio_row_oe = 8'h40; gpio_row_do = 8'h40;
    gpio_col_oe = 8'h04; gpio_col_do = 8'h04;
    tick(5*SCAN);
    expect_v(2, k8, "R9 disabled row reads released");
    expect_v(4, k28|k55, "R9 release via disable");
    expect_v(7, 64'h40, "R9 row oe");
    expect_v(1, 64'h04, "R9 col gpio data");
    settle();

    // R8 standby and R2 glitch
    keys = '0;
    glmin = 4'd4;
    tick(5*SCAN);
    expect_v(2, 0, "R8 all released");
    standby = 1'b1;
    tick(2);
    expect_v(0, 64'hFF, "R8 all columns driven");
    expect_v(1, 64'h04, "R8 col data");
    gl_mask = 8'h08;
    tick(3);
    gl_mask = '0;
    tick(20);
    expect_v(6, 0, "R2 short pulse rejected");
    settle();
    keys = k25;
    tick(20);
    expect_v(6, 1, "R8 wake on press");
    expect_v(2, 0, "R8 no sample in standby");
    settle();
    tick(5*SCAN);
    expect_v(2, k25, "R8 scanning resumed");
    settle();
    standby = 1'b0;
    keys = '0;
    wake_clr = 1'b1;
    tick(1);
    wake_clr = 1'b0;
    expect_v(6, 0, "R8 wake cleared");
    settle();
    tick(2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule